// File: doc/BRIEF.md
# DDR2 Command Sequencer With Open-Row Tracking

This block sits between a simple burst-request port and the command pins of a DDR2 memory with four banks. Each request names a direction (read or write), a bank, a row, a column and an auto-precharge flag. The block keeps a table of which row is open in each bank. From that table it decides whether the request needs an activate, a precharge and then an activate, or only a column command. It then drives the active-low chip-select, row-strobe, column-strobe and write-enable pins, together with the bank and address pins, using registered outputs that the memory samples on the next rising edge.

Requests to a row that is already open go straight to a column command. Column commands are spaced by half the burst length (burst length 8, so 4 cycles), which is the time the data bus needs for one burst. Moving to another bank leaves the rows of the other banks open. This lets traffic interleave across banks without the precharge and activate gaps that a row conflict in one bank costs. A refresh request closes every open row with a single precharge-all and then issues an auto-refresh. After that it marks all banks closed and pulses a done flag. The data path, strobe alignment, power-up mode programming and calibration are outside this block. Everything runs on one clock.

Top module: `ddr2_cmd_seq`

## Requirements
- R1: During reset the chip select is high (deselect). After reset, and in every cycle with no command, the pins show a NOP: row strobe, column strobe and write enable all high, chip select low, bank and address zero. req_ack and ref_done stay low.
- R2: The strobes form the triple {ras_n,cas_n,we_n}. The encodings are: activate 011, read 101, write 100, precharge 010, auto-refresh 001, NOP 111.
- R3: The activate places the row on mem_addr[12:0]. A read or write places the column on mem_addr[9:0] and the auto-precharge flag on mem_addr[10], with mem_addr[12:11] zero. A single-bank precharge has mem_addr[10]=0, and a precharge-all has mem_addr[10]=1. mem_ba always carries the request's bank.
- R4: A request to a closed bank gets an activate, and then its column command exactly T_RCD cycles later.
- R5: A request that hits the open row of its bank gets no activate and no precharge. Column commands are at least BURST_LEN/2 cycles apart, and exactly that far apart when the requests arrive back to back.
- R6: A request to a bank whose open row differs gets a precharge of that bank, an activate exactly T_RP cycles after it, and its column command exactly T_RCD cycles after the activate.
- R7: Each bank keeps its own open row. Serving another bank neither closes it nor changes it.
- R8: A column command with the auto-precharge flag closes its bank. The next activate to that bank comes exactly BURST_LEN/2+T_RP cycles after that column command when the next request is already waiting.
- R9: A refresh with any bank open issues one precharge-all, then the auto-refresh exactly T_RP cycles later. Afterwards every bank counts as closed, so the next request activates without a precharge.
- R10: A refresh with no bank open issues the auto-refresh without a precharge. ref_done is a single-cycle pulse exactly T_RFC cycles after the auto-refresh.
- R11: From the cycle after ref_req until ref_done pulses, req_ready is low. A request that waits during that time is served after ref_done.
- R12: A request is taken only in a cycle with req_valid and req_ready both high. req_ack pulses for one cycle, in the same cycle the column command for that request appears on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the memory samples pins on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Target row |
| req_col | input | 10 | Burst start column |
| req_autopre | input | 1 | Close the row after this access |
| req_ack | output | 1 | Pulse: column command for the request issued |
| ref_req | input | 1 | Single-cycle refresh request pulse |
| ref_done | output | 1 | Pulse: refresh finished, all banks closed |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | 2 | Bank address |
| mem_addr | output | 13 | Row / column address |

## Verification
The assertions assume the following about the inputs. ref_req arrives as a one-cycle pulse. The request fields are valid whenever req_valid and req_ready are both high. The timing parameters are at least one. The stimulus holds req_valid with steady fields until it sees req_ready high. It raises ref_req for exactly one cycle and only while no refresh is outstanding. It uses only banks 0 to 3 and rows and columns inside their widths, so every activate goes to a bank the table shows closed and every column command finds its row open.

// File: rtl/ddr2_seq_pkg.sv
// Shared encodings for the DDR2 command sequencer.
// Assumes the strobe triple is ordered {ras_n, cas_n, we_n}.
package ddr2_seq_pkg;

    // Active-low strobe patterns for each memory command.
    typedef enum logic [2:0] {
        CMD_NOP = 3'b111,
        CMD_ACT = 3'b011,
        CMD_RD  = 3'b101,
        CMD_WR  = 3'b100,
        CMD_PRE = 3'b010,
        CMD_REF = 3'b001
    } mem_cmd_e;

    // Sequencer control states.
    typedef enum logic [2:0] {
        S_IDLE,
        S_WORK,
        S_REF_PRE,
        S_REF_CMD,
        S_REF_WAIT
    } seq_state_e;

endpackage

// File: rtl/ddr2_wait_timer.sv
// Down-counter that enforces a minimum spacing between commands.
// Loading N-1 in the cycle a command is registered lets the dependent
// command appear N cycles later. Assumes load values fit in CNT_W bits.
module ddr2_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // Count down to zero; a new load overrides the count.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // A non-zero load must hold off the next dependent command (R4).
    p_load_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !done);

endmodule

// File: rtl/ddr2_row_table.sv
// Per-bank open-row table. One entry per bank holds an open flag and the
// row number. Answers whether the queried bank is open and whether its row
// matches. Assumes at most one of open/close/close_all per cycle.
module ddr2_row_table #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] q_bank,
    input  logic [ROW_W-1:0]  q_row,
    output logic              q_open,
    output logic              q_hit,
    output logic              any_open,
    input  logic              open_en,
    input  logic              close_en,
    input  logic              close_all,
    input  logic [BANK_W-1:0] upd_bank,
    input  logic [ROW_W-1:0]  upd_row
);
    localparam int NBANKS = 1 << BANK_W;

    logic [NBANKS-1:0]            open_vec;
    logic [NBANKS-1:0][ROW_W-1:0] row_vec;

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        logic             open_r;
        logic [ROW_W-1:0] row_r;

        // Track the open state and row of this bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_r <= 1'b0;
                row_r  <= '0;
            end else if (close_all) begin
                open_r <= 1'b0;
            end else if (open_en && upd_bank == BANK_W'(b)) begin
                open_r <= 1'b1;
                row_r  <= upd_row;
            end else if (close_en && upd_bank == BANK_W'(b)) begin
                open_r <= 1'b0;
            end
        end

        assign open_vec[b] = open_r;
        assign row_vec[b]  = row_r;
    end

    assign q_open   = open_vec[q_bank];
    assign q_hit    = (row_vec[q_bank] == q_row);
    assign any_open = |open_vec;

    // An activate only ever targets a closed bank (R4).
    p_act_on_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        open_en |-> !open_vec[upd_bank]);

    // A bank is only closed while it is open (R6).
    p_close_on_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        close_en |-> open_vec[upd_bank]);

    // After a precharge-all no bank is left open (R9).
    p_all_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        close_all |=> !any_open);

endmodule

// File: rtl/ddr2_pin_drive.sv
// Output register stage for the memory command pins. The memory samples
// these on the rising edge, so every pin leaves a flop. Chip select stays
// high while reset is held and low afterwards.
module ddr2_pin_drive
    import ddr2_seq_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mem_cmd_e          cmd,
    input  logic [BANK_W-1:0] ba,
    input  logic [ADDR_W-1:0] addr,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BANK_W-1:0] ba_o,
    output logic [ADDR_W-1:0] addr_o
);
    // Register the command, bank and address onto the pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n   <= 1'b1;
            ras_n  <= 1'b1;
            cas_n  <= 1'b1;
            we_n   <= 1'b1;
            ba_o   <= '0;
            addr_o <= '0;
        end else begin
            cs_n                 <= 1'b0;
            {ras_n, cas_n, we_n} <= cmd;
            ba_o                 <= ba;
            addr_o               <= addr;
        end
    end

    // Only the defined command patterns reach the pins (R2).
    p_legal_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> ({ras_n, cas_n, we_n} inside {3'b111, 3'b011, 3'b101,
                                                3'b100, 3'b010, 3'b001}));

    // A NOP leaves bank and address at zero (R1).
    p_nop_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && ras_n && cas_n && we_n) |-> (ba_o == '0 && addr_o == '0));

endmodule

// File: rtl/ddr2_cmd_seq.sv
// DDR2 command sequencer with per-bank open-row tracking.
// Takes one burst request at a time over a ready/valid port and emits
// activate / precharge / read / write commands as the row table requires.
// Refresh closes all rows with one precharge-all, then auto-refreshes.
// Assumes ref_req is a one-cycle pulse and all T_* parameters are >= 1.
module ddr2_cmd_seq
    import ddr2_seq_pkg::*;
#(
    parameter int BANK_W    = 2,
    parameter int ADDR_W    = 13,
    parameter int COL_W     = 10,
    parameter int BURST_LEN = 8,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RFC     = 8,
    parameter int CNT_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ADDR_W-1:0] req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_autopre,
    output logic              req_ack,
    input  logic              ref_req,
    output logic              ref_done,
    output logic              mem_cs_n,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [BANK_W-1:0] mem_ba,
    output logic [ADDR_W-1:0] mem_addr
);
    localparam int ROW_W   = ADDR_W;
    localparam int AP_BIT  = 10;
    localparam int COL_GAP = BURST_LEN / 2;
    localparam int AP_WAIT = COL_GAP + T_RP;

    localparam logic [CNT_W-1:0] LD_RCD = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] LD_RFC = CNT_W'(T_RFC - 1);
    localparam logic [CNT_W-1:0] LD_AP  = CNT_W'(AP_WAIT - 1);
    localparam logic [CNT_W-1:0] LD_GAP = CNT_W'(COL_GAP - 1);

    seq_state_e        state_q, state_n;
    logic              ref_pend_q;
    logic              cur_write_q, cur_ap_q;
    logic [BANK_W-1:0] cur_bank_q;
    logic [ROW_W-1:0]  cur_row_q;
    logic [COL_W-1:0]  cur_col_q;
    logic              accept;

    mem_cmd_e          cmd;
    logic [BANK_W-1:0] cmd_ba;
    logic [ADDR_W-1:0] cmd_addr;
    logic              tmr_load, gap_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_done, gap_done;
    logic              open_en, close_en, close_all;
    logic              q_open, q_hit, any_open;
    logic              ack_n, done_n;

    assign req_ready = (state_q == S_IDLE) && !ref_pend_q;
    assign accept    = req_valid && req_ready;

    ddr2_row_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_rows (
        .clk(clk), .rst_n(rst_n),
        .q_bank(cur_bank_q), .q_row(cur_row_q),
        .q_open(q_open), .q_hit(q_hit), .any_open(any_open),
        .open_en(open_en), .close_en(close_en), .close_all(close_all),
        .upd_bank(cur_bank_q), .upd_row(cur_row_q)
    );

    // Shared timer for activate/precharge/refresh spacing.
    ddr2_wait_timer #(.CNT_W(CNT_W)) u_cmd_tmr (
        .clk(clk), .rst_n(rst_n),
        .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    // Column-to-column spacing timer (one burst on the data bus).
    ddr2_wait_timer #(.CNT_W(CNT_W)) u_gap_tmr (
        .clk(clk), .rst_n(rst_n),
        .load(gap_load), .load_val(LD_GAP), .done(gap_done)
    );

    ddr2_pin_drive #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_pins (
        .clk(clk), .rst_n(rst_n),
        .cmd(cmd), .ba(cmd_ba), .addr(cmd_addr),
        .cs_n(mem_cs_n), .ras_n(mem_ras_n), .cas_n(mem_cas_n), .we_n(mem_we_n),
        .ba_o(mem_ba), .addr_o(mem_addr)
    );

    // Choose the next command from the state, the row table and the timers.
    always_comb begin
        state_n   = state_q;
        cmd       = CMD_NOP;
        cmd_ba    = '0;
        cmd_addr  = '0;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        gap_load  = 1'b0;
        open_en   = 1'b0;
        close_en  = 1'b0;
        close_all = 1'b0;
        ack_n     = 1'b0;
        done_n    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (accept)          state_n = S_WORK;
                else if (ref_pend_q) state_n = S_REF_PRE;
            end
            S_WORK: begin
                if (tmr_done) begin
                    if (q_open && q_hit) begin
                        if (gap_done) begin
                            cmd                    = cur_write_q ? CMD_WR : CMD_RD;
                            cmd_ba                 = cur_bank_q;
                            cmd_addr[COL_W-1:0]    = cur_col_q;
                            cmd_addr[AP_BIT]       = cur_ap_q;
                            gap_load               = 1'b1;
                            ack_n                  = 1'b1;
                            state_n                = S_IDLE;
                            if (cur_ap_q) begin
                                close_en = 1'b1;
                                tmr_load = 1'b1;
                                tmr_val  = LD_AP;
                            end
                        end
                    end else if (q_open) begin
                        if (gap_done) begin
                            cmd      = CMD_PRE;
                            cmd_ba   = cur_bank_q;
                            close_en = 1'b1;
                            tmr_load = 1'b1;
                            tmr_val  = LD_RP;
                        end
                    end else begin
                        cmd      = CMD_ACT;
                        cmd_ba   = cur_bank_q;
                        cmd_addr = cur_row_q;
                        open_en  = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = LD_RCD;
                    end
                end
            end
            S_REF_PRE: begin
                if (tmr_done && gap_done) begin
                    if (any_open) begin
                        cmd              = CMD_PRE;
                        cmd_addr[AP_BIT] = 1'b1;
                        close_all        = 1'b1;
                        tmr_load         = 1'b1;
                        tmr_val          = LD_RP;
                    end
                    state_n = S_REF_CMD;
                end
            end
            S_REF_CMD: begin
                if (tmr_done) begin
                    cmd      = CMD_REF;
                    tmr_load = 1'b1;
                    tmr_val  = LD_RFC;
                    state_n  = S_REF_WAIT;
                end
            end
            S_REF_WAIT: begin
                if (tmr_done) begin
                    done_n  = 1'b1;
                    state_n = S_IDLE;
                end
            end
            default: state_n = S_IDLE;
        endcase
    end

    // State, pending refresh flag and registered status pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            ref_pend_q <= 1'b0;
            req_ack    <= 1'b0;
            ref_done   <= 1'b0;
        end else begin
            state_q    <= state_n;
            ref_pend_q <= ref_req | (ref_pend_q & ~done_n);
            req_ack    <= ack_n;
            ref_done   <= done_n;
        end
    end

    // Capture the request fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_write_q <= 1'b0;
            cur_ap_q    <= 1'b0;
            cur_bank_q  <= '0;
            cur_row_q   <= '0;
            cur_col_q   <= '0;
        end else if (accept) begin
            cur_write_q <= req_write;
            cur_ap_q    <= req_autopre;
            cur_bank_q  <= req_bank;
            cur_row_q   <= req_row;
            cur_col_q   <= req_col;
        end
    end

    // The acknowledge coincides with a column command on the pins (R12).
    p_ack_is_column_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> (!mem_cas_n && mem_ras_n));

    // A refresh request closes the request port next cycle (R11).
    p_ref_blocks_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req |=> !req_ready);

    // The refresh-done flag is a single-cycle pulse (R10).
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ref_done |=> !ref_done);

    // Auto-refresh is only issued with every bank closed (R9).
    p_ref_all_closed_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REF) |-> !any_open);

    // A column command always finds its row open (R5).
    p_col_needs_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RD || cmd == CMD_WR) |-> (q_open && q_hit));

endmodule

// File: tb/ddr2_cmd_seq_test.sv
// Directed bench for the DDR2 command sequencer: one task per scenario.
module ddr2_cmd_seq_test;
    localparam int T_RCD = 3, T_RP = 3, T_RFC = 8, BURST_LEN = 8;
    localparam int GAP = BURST_LEN / 2;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_autopre = 1'b0, ref_req = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [12:0] req_row = '0;
    logic [9:0]  req_col = '0;
    logic        req_ready, req_ack, ref_done;
    logic        mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
    logic [1:0]  mem_ba;
    logic [12:0] mem_addr;

    ddr2_cmd_seq #(.T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .BURST_LEN(BURST_LEN)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_autopre(req_autopre), .req_ack(req_ack),
        .ref_req(ref_req), .ref_done(ref_done),
        .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
        .mem_we_n(mem_we_n), .mem_ba(mem_ba), .mem_addr(mem_addr)
    );

    always #5 clk = ~clk;

    localparam logic [2:0] NOP = 3'b111, ACT = 3'b011, RD = 3'b101,
                           WR = 3'b100, PRE = 3'b010, REF = 3'b001;

    int n_chk = 0, n_err = 0;
    int cyc = 0, n_log = 0;
    logic [2:0]  cmd_log [64];
    logic [1:0]  ba_log  [64];
    logic [12:0] addr_log[64];
    int          cyc_log [64];
    int ack_cnt = 0, ack_cyc = 0, done_cnt = 0, done_cyc = 0;

    // Pin monitor: samples away from the rising edge and logs every command.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if ({mem_ras_n, mem_cas_n, mem_we_n} != NOP && n_log < 64) begin
                cmd_log[n_log]  = {mem_ras_n, mem_cas_n, mem_we_n};
                ba_log[n_log]   = mem_ba;
                addr_log[n_log] = mem_addr;
                cyc_log[n_log]  = cyc;
                n_log++;
            end
            if (req_ack)  begin ack_cnt++;  ack_cyc  = cyc; end
            if (ref_done) begin done_cnt++; done_cyc = cyc; end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_log();
        n_log = 0; ack_cnt = 0; done_cnt = 0;
    endtask

    task automatic settle();
        repeat (30) @(negedge clk);
    endtask

    // Hold a request until the port takes it.
    task automatic send(input logic wr, input logic [1:0] b, input logic [12:0] r,
                        input logic [9:0] c, input logic ap);
        req_valid = 1'b1; req_write = wr; req_bank = b;
        req_row = r; req_col = c; req_autopre = ap;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic pulse_ref();
        ref_req = 1'b1;
        @(negedge clk);
        ref_req = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 cs_n in reset", int'(mem_cs_n), 1);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle strobes", int'({mem_ras_n, mem_cas_n, mem_we_n}), int'(NOP));
        chk("R1 cs_n after reset", int'(mem_cs_n), 0);
        chk("R1 addr zero", int'(mem_addr), 0);
        chk("R1 ack low", int'(req_ack), 0);
        chk("R1 done low", int'(ref_done), 0);
        chk("R12 ready after reset", int'(req_ready), 1);
    endtask

    task automatic t_ref_empty();
        clear_log();
        pulse_ref();
        chk("R11 ready low after ref_req", int'(req_ready), 0);
        settle();
        chk("R10 only refresh issued", n_log, 1);
        chk("R10 refresh code", int'(cmd_log[0]), int'(REF));
        chk("R10 one done pulse", done_cnt, 1);
        chk("R10 done delay", done_cyc - cyc_log[0], T_RFC);
        chk("R11 ready back", int'(req_ready), 1);
    endtask

    task automatic t_closed_write();
        clear_log();
        send(1'b1, 2'd1, 13'h000C, 10'h000, 1'b0);
        settle();
        chk("R4 two commands", n_log, 2);
        chk("R2 activate code", int'(cmd_log[0]), int'(ACT));
        chk("R3 activate bank", int'(ba_log[0]), 1);
        chk("R3 activate row", int'(addr_log[0]), 'h000C);
        chk("R2 write code", int'(cmd_log[1]), int'(WR));
        chk("R3 write column", int'(addr_log[1]), 0);
        chk("R4 act to write", cyc_log[1] - cyc_log[0], T_RCD);
        chk("R12 ack with column", ack_cyc, cyc_log[1]);
        chk("R12 one ack", ack_cnt, 1);
    endtask

    task automatic t_row_hits();
        clear_log();
        for (int i = 1; i <= 4; i++) send(1'b0, 2'd1, 13'h000C, 10'(8 * i), 1'b0);
        settle();
        chk("R5 only columns", n_log, 4);
        for (int i = 0; i < 4; i++) begin
            chk("R5 read code", int'(cmd_log[i]), int'(RD));
            chk("R3 read column", int'(addr_log[i]), 8 * (i + 1));
        end
        for (int i = 1; i < 4; i++) chk("R5 column spacing", cyc_log[i] - cyc_log[i-1], GAP);
        chk("R5 acks", ack_cnt, 4);
    endtask

    task automatic t_row_miss();
        clear_log();
        send(1'b1, 2'd1, 13'h1234, 10'h155, 1'b0);
        settle();
        chk("R6 three commands", n_log, 3);
        chk("R6 precharge code", int'(cmd_log[0]), int'(PRE));
        chk("R3 single precharge A10", int'(addr_log[0][10]), 0);
        chk("R6 precharge bank", int'(ba_log[0]), 1);
        chk("R6 activate code", int'(cmd_log[1]), int'(ACT));
        chk("R3 new row", int'(addr_log[1]), 'h1234);
        chk("R6 pre to act", cyc_log[1] - cyc_log[0], T_RP);
        chk("R6 act to write", cyc_log[2] - cyc_log[1], T_RCD);
        chk("R3 write column", int'(addr_log[2]), 'h155);
    endtask

    task automatic t_interleave();
        clear_log();
        send(1'b0, 2'd2, 13'h0005, 10'h007, 1'b0);
        send(1'b0, 2'd1, 13'h1234, 10'h001, 1'b0);
        settle();
        chk("R7 command count", n_log, 3);
        chk("R7 activate other bank", int'(cmd_log[0]), int'(ACT));
        chk("R7 other bank", int'(ba_log[0]), 2);
        chk("R7 read bank2", int'(cmd_log[1]), int'(RD));
        chk("R7 bank1 still open", int'(cmd_log[2]), int'(RD));
        chk("R7 bank1 read bank", int'(ba_log[2]), 1);
    endtask

    task automatic t_autopre();
        clear_log();
        send(1'b0, 2'd2, 13'h0005, 10'h003, 1'b1);
        send(1'b0, 2'd2, 13'h0005, 10'h004, 1'b0);
        settle();
        chk("R8 command count", n_log, 3);
        chk("R8 read with flag", int'(addr_log[0]), 'h403);
        chk("R8 reactivate", int'(cmd_log[1]), int'(ACT));
        chk("R8 ap wait", cyc_log[1] - cyc_log[0], GAP + T_RP);
        chk("R8 read after act", cyc_log[2] - cyc_log[1], T_RCD);
    endtask

    task automatic t_ref_open();
        clear_log();
        pulse_ref();
        chk("R11 ready low", int'(req_ready), 0);
        settle();
        chk("R9 two commands", n_log, 2);
        chk("R9 precharge all code", int'(cmd_log[0]), int'(PRE));
        chk("R3 precharge all A10", int'(addr_log[0][10]), 1);
        chk("R9 refresh code", int'(cmd_log[1]), int'(REF));
        chk("R9 pre to refresh", cyc_log[1] - cyc_log[0], T_RP);
        chk("R10 done delay", done_cyc - cyc_log[1], T_RFC);
        clear_log();
        send(1'b0, 2'd1, 13'h1234, 10'h002, 1'b0);
        settle();
        chk("R9 reopen without precharge", int'(cmd_log[0]), int'(ACT));
        chk("R9 reopen count", n_log, 2);
    endtask

    task automatic t_ref_wait_req();
        clear_log();
        pulse_ref();
        send(1'b1, 2'd3, 13'h0ABC, 10'h010, 1'b0);
        settle();
        chk("R11 command count", n_log, 4);
        chk("R11 activate", int'(cmd_log[2]), int'(ACT));
        chk("R11 served after done", int'(cyc_log[2] > done_cyc), 1);
        chk("R11 one done", done_cnt, 1);
        chk("R12 one ack", ack_cnt, 1);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_ref_empty();
        t_closed_write();
        t_row_hits();
        t_row_miss();
        t_interleave();
        t_autopre();
        t_ref_open();
        t_ref_wait_req();
        finish_run();
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end
endmodule